// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic use an external asynchronous static RAM that holds 256K words of 16 bits, with a separate active-low enable for each byte lane. On the host side, a request carries an address, write data, a write flag and a per-byte mask. The request uses a valid/ready handshake. The block accepts a request only when `req_ready` is high, so a host that sees `req_ready` low must hold its request steady until it is taken. Read results come back as a one-cycle `rsp_valid` pulse with `rsp_rdata`. The response port has no back-pressure, so the host must be able to take a response in any cycle.

On the memory side, the controller registers the address, the mask and the write data when it accepts a request. It then works through fixed phases, each timed by a count of controller clock cycles:
- A write has a setup phase, a write-enable-low phase and a recovery phase.
- A read has an access phase and a recovery phase.

The bidirectional data bus appears as three signals: an output value, an output enable and an input value. Output enable on the memory stays high for the whole of every write. The controller never drives the bus in the cycle before it lowers output enable for a read.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1. In the same period chip select, output enable, write enable and both byte enables are all high, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. After that edge, `req_ready` stays low for the length of the operation and then returns to 1:
  - a write takes SETUP_CYC + WE_CYC + RECOV_CYC cycles;
  - a read takes ACCESS_CYC + RECOV_CYC cycles.
- R3: A write holds chip select low with write enable high for SETUP_CYC cycles, then holds write enable low for exactly WE_CYC cycles. The controller drives the data bus in both phases. Output enable stays high throughout the write.
- R4: Mask bit 1 controls the upper lane (data bits 15..8) through `mem_be_n[1]`, and mask bit 0 controls the lower lane (bits 7..0) through `mem_be_n[0]`. A lane's enable is low only while chip select is low and its mask bit is 1. Only those lanes are stored.
- R5: A read holds chip select and output enable low, with write enable high, for ACCESS_CYC cycles. The controller samples the bus on the last edge of that phase. `rsp_valid` is high for exactly one cycle, which is cycle ACCESS_CYC+1 after acceptance. Lanes whose mask bit is 0 return zero.
- R6: The controller never drives the data bus while output enable is low. It also never drives the bus in the cycle just before output enable falls.
- R7: Whenever chip select is high, write enable, output enable and both byte enables are high and the bus is released. This includes every recovery cycle.
- R8: A write with mask 00 stores nothing. A read with mask 00 returns 0.
- R9: While chip select stays low, `mem_addr` is stable and equals the address of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte lanes to access, bit 1 = upper |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Read data, masked lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte enables, active low, bit 1 = upper |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The assertions check several rules on every cycle:
- write enable and output enable are never low together;
- a write pulse lasts exactly WE_CYC cycles and is preceded by a driven setup cycle;
- the bus is released before a read turns on the memory's drivers;
- the address stays stable while the memory is selected;
- the deselect state is clean;
- a response lasts one cycle and `req_ready` drops after acceptance.

Only the bench scenarios can show the rest. These are that the right lanes are stored and returned across every mask, that mask 00 leaves memory untouched, that busy periods have exactly the configured lengths, and that no bus contention occurs against a behavioural memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WSETUP  = 3'd1,
    ST_WPULSE  = 3'd2,
    ST_RACCESS = 3'd3,
    ST_RECOVER = 3'd4
  } ctrl_state_e;
endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic [LANES-1:0]  mask,
  input  logic              active,
  input  logic [DATA_W-1:0] rd_raw,
  output logic [LANES-1:0]  be_n,
  output logic [DATA_W-1:0] rd_masked
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // Enable is low only during a selected phase with the lane requested
    assign be_n[i] = !(active && mask[i]);
    assign rd_masked[i*8 +: 8] = mask[i] ? rd_raw[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int SETUP_CYC  = 1,
  parameter int WE_CYC     = 1,
  parameter int ACCESS_CYC = 2,
  parameter int RECOV_CYC  = 1,
  localparam int LANES     = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int MAX_WR  = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int MAX_RD  = (ACCESS_CYC > RECOV_CYC) ? ACCESS_CYC : RECOV_CYC;
  localparam int MAX_CYC = (MAX_WR > MAX_RD) ? MAX_WR : MAX_RD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e       state_q, state_d;
  logic              tmr_load, tmr_done, capture, active;
  logic [CNT_W-1:0]  tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rd_masked;
  logic [LANES-1:0]  mask_q;
  logic              rsp_valid_q;

  sram_cycle_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_we) begin
          state_d = ST_WSETUP;
          tmr_val = CNT_W'(SETUP_CYC - 1);
        end else begin
          state_d = ST_RACCESS;
          tmr_val = CNT_W'(ACCESS_CYC - 1);
        end
      end
      ST_WSETUP: if (tmr_done) begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WE_CYC - 1);
      end
      ST_WPULSE: if (tmr_done) begin
        state_d  = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RECOV_CYC - 1);
      end
      ST_RACCESS: if (tmr_done) begin
        capture  = 1'b1;
        state_d  = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RECOV_CYC - 1);
      end
      ST_RECOVER: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      mask_q      <= '0;
      rdata_q     <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= capture;
      if (state_q == ST_IDLE && req_valid) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
      end
      if (capture) rdata_q <= rd_masked;
    end
  end

  assign active = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                  (state_q == ST_RACCESS);

  sram_lane_map #(.DATA_W(DATA_W)) lanes_i (
    .mask      (mask_q),
    .active    (active),
    .rd_raw    (mem_dq_in),
    .be_n      (mem_be_n),
    .rd_masked (rd_masked)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_cs_n   = !active;
  assign mem_we_n   = (state_q != ST_WPULSE);
  assign mem_oe_n   = (state_q != ST_RACCESS);
  assign mem_dq_oe  = (state_q == ST_WSETUP) || (state_q == ST_WPULSE);
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rdata_q;

  // Checker state: length of the current write-enable-low run
  logic [CNT_W:0] we_lo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_lo_cnt <= '0;
    else if (!mem_we_n) we_lo_cnt <= we_lo_cnt + 1'b1;
    else                we_lo_cnt <= '0;
  end

  assert_oe_high_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && $past(!mem_we_n)) |-> (we_lo_cnt == (CNT_W+1)'(WE_CYC)));
  assert_setup_before_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && $past(!mem_cs_n)));
  assert_bus_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));
  assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_we_n && mem_oe_n && (&mem_be_n) && !mem_dq_oe));
  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  assert_rsp_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/async_sram_ctrl_tb_top.sv
module sram_behav_model #(
  parameter int ADDR_W = 18,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [1:0]        be_n,
  input  logic [15:0]       dq_wr,
  input  logic              dq_wr_oe,
  output logic [15:0]       dq_rd,
  output logic              drives
);
  logic [15:0] mem [1<<IDX_W];
  logic        rd_en;

  initial begin
    for (int i = 0; i < (1 << IDX_W); i++) mem[i] = 16'((i * 16'h0101) ^ 16'h5A3C);
  end

  always @(posedge clk) begin
    if (!cs_n && !we_n && dq_wr_oe) begin
      if (!be_n[0]) mem[addr[IDX_W-1:0]][7:0]  <= dq_wr[7:0];
      if (!be_n[1]) mem[addr[IDX_W-1:0]][15:8] <= dq_wr[15:8];
    end
  end

  assign rd_en = !cs_n && !oe_n && we_n;
  assign dq_rd = {(rd_en && !be_n[1]) ? mem[addr[IDX_W-1:0]][15:8] : 8'h00,
                  (rd_en && !be_n[0]) ? mem[addr[IDX_W-1:0]][7:0]  : 8'h00};
  assign drives = rd_en && (be_n != 2'b11);
endmodule

module async_sram_ctrl_tb_top;
  localparam int ADDR_W = 18;
  localparam int S = 1, W = 2, A = 3, RC = 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, mdrv;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;
  logic [1:0]  mem_be_n;

  int tests = 0, fails = 0;
  logic [15:0] shadow [64];

  always #4 clk = ~clk;

  async_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(16), .SETUP_CYC(S), .WE_CYC(W),
                    .ACCESS_CYC(A), .RECOV_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  sram_behav_model #(.ADDR_W(ADDR_W), .IDX_W(6)) model_i (
    .clk(clk), .addr(mem_addr), .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .be_n(mem_be_n), .dq_wr(mem_dq_out), .dq_wr_oe(mem_dq_oe), .dq_rd(mem_dq_in),
    .drives(mdrv));

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mk_addr(input int a);
    return {12'((a * 37 + 5) & 12'hFFF), 6'(a)};
  endfunction

  task automatic do_op(input logic we, input int a, input logic [1:0] m, input logic [15:0] d);
    int busy = 0, we_lo = 0, oe_lo = 0, rsp_cnt = 0, rsp_cyc = 0;
    logic lane_ok = 1'b1, addr_ok = 1'b1, bus_ok = 1'b1;
    logic [15:0] got = '0, exp_rd;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = mk_addr(a); req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d; req_addr = ~req_addr;
    for (int k = 1; k < 64; k++) begin
      if (req_ready) break;
      busy++;
      if (!mem_we_n) we_lo++;
      if (we && !mem_oe_n) oe_lo++;
      if (!mem_cs_n) begin
        if (mem_be_n != ~m) lane_ok = 1'b0;
        if (mem_addr != mk_addr(a)) addr_ok = 1'b0;
      end
      if (mdrv && mem_dq_oe) bus_ok = 1'b0;
      if (rsp_valid) begin rsp_cnt++; rsp_cyc = k; got = rsp_rdata; end
      @(negedge clk);
    end
    chk(busy == (we ? S + W + RC : A + RC), "R2 busy length", busy, we ? S + W + RC : A + RC);
    chk(lane_ok, "R4 byte enable pins", 0, 1);
    chk(addr_ok, "R9 address held", 0, 1);
    chk(bus_ok, "R6 no contention", 0, 1);
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
        "R7 idle deselected", {mem_cs_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 6'b111110);
    if (we) begin
      chk(we_lo == W, "R3 write pulse width", we_lo, W);
      chk(oe_lo == 0 && rsp_cnt == 0, "R3 oe high during write", oe_lo, 0);
      if (m[0]) shadow[a][7:0]  = d[7:0];
      if (m[1]) shadow[a][15:8] = d[15:8];
    end else begin
      exp_rd = {m[1] ? shadow[a][15:8] : 8'h00, m[0] ? shadow[a][7:0] : 8'h00};
      chk(rsp_cnt == 1 && rsp_cyc == A + 1, "R5 response timing", rsp_cyc, A + 1);
      chk(got == exp_rd, m == 2'b00 ? "R8 empty-mask read" : "R5 read data", got, exp_rd);
      chk(we_lo == 0, "R5 write enable high in read", we_lo, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) shadow[i] = 16'((i * 16'h0101) ^ 16'h5A3C);
    repeat (3) @(negedge clk);
    chk(req_ready && mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 &&
        !mem_dq_oe && !rsp_valid, "R1 reset state", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_cs_n && !rsp_valid, "R1 after reset", req_ready, 1);
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 4; m++) begin
          do_op(1'b1, a, 2'(m), 16'((a * 977 + m * 131 + p * 4099) & 16'hFFFF));
          do_op(1'b0, a, 2'(m + p + 1), 16'h0);
        end
    // R8: empty-mask write must leave word intact, confirmed by a full read
    do_op(1'b1, 7, 2'b00, 16'hDEAD);
    do_op(1'b0, 7, 2'b11, 16'h0);
    for (int a = 0; a < 16; a++) do_op(1'b0, a, 2'b11, 16'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule